// File: doc/BRIEF.md
# Serial Control Word Receiver

This block is the slave side of a three-line serial configuration port. A host drives a serial clock, a data line and a separate latch line. On each rising edge of the serial clock the block shifts in one data bit, most significant bit first. When the latch line rises, the block takes the last 16 bits it shifted in and issues them as one register write. The upper 7 bits of the word give the register address and the lower 9 bits give the register data.

All three serial lines are asynchronous to the system clock. Each line passes through a two-flop synchronizer, and edge detection runs on the synchronized copies. A write appears as a single-cycle strobe, and the address and data travel with it on registered outputs. If fewer than 16 bits have arrived since the previous latch edge, the block drops the word and pulses an error flag instead of the strobe. The bit count clears on every latch rising edge, so each word is counted on its own.

Top module: `ctrl_word_rx`

## Requirements
- R1: While reset is asserted and after it is released, `wr_en_o` and `err_o` are 0, and `wr_addr_o` and `wr_data_o` are all zeros.
- R2: Bits are sampled on rising edges of `ser_clk_i` and shifted in MSB first. For the committed 16-bit word, bits [15:9] appear on `wr_addr_o` and bits [8:0] appear on `wr_data_o`.
- R3: A rising edge of `ser_latch_i` that follows at least 16 shifted bits produces exactly one `wr_en_o` pulse, one system clock cycle long, with the address and data valid in that same cycle.
- R4: A high level on `ser_latch_i` has no effect by itself. Bits shifted while the latch line stays high produce no strobe and no error until the next rising edge of the latch line.
- R5: A rising edge of the latch line after fewer than 16 bits produces a single-cycle `err_o` pulse and no `wr_en_o`, and it leaves `wr_addr_o` and `wr_data_o` unchanged.
- R6: When more than 16 bits arrive before the latch edge, the write carries the last 16 bits received.
- R7: Every rising edge of the latch line clears the bit count. A word of 15 bits that follows a successful write is reported as an error.
- R8: When a serial clock rising edge and a latch rising edge are detected in the same system clock cycle, the bit from that serial edge is counted and included in the committed word.
- R9: `wr_addr_o` and `wr_data_o` change only in a cycle where `wr_en_o` is 1.
- R10: `wr_en_o` and `err_o` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous |
| ser_dat_i | input | 1 | Serial data, sampled on serial clock rise |
| ser_latch_i | input | 1 | Latch line; its rising edge commits the word |
| wr_en_o | output | 1 | One-cycle register write strobe |
| wr_addr_o | output | 7 | Register address of the last write |
| wr_data_o | output | 9 | Register data of the last write |
| err_o | output | 1 | One-cycle pulse for a short word at the latch edge |

## Verification
The case of interest is a latch rising edge that lands in the same synchronized cycle as the serial clock edge carrying the sixteenth bit. The bench provokes it by sending 15 bits and then raising the serial clock and the latch line together on one system clock edge. The result is judged correct only if a write strobe follows, with no error pulse, and the word includes the final bit in its least significant position. A design that commits before it shifts would report an error, or it would write the wrong data.

// File: rtl/ctrl_word_pkg.sv
package ctrl_word_pkg;
  parameter int unsigned WORD_W = 16;
  parameter int unsigned ADDR_W = 7;
  parameter int unsigned DATA_W = WORD_W - ADDR_W;
  parameter int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/cw_sync.sv
module cw_sync #(
  parameter int unsigned N      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] pipe_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q[s] <= '0;
      else if (s == 0) pipe_q[s] <= async_i;
      else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s - 1];
    end
  end

  assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/cw_rise.sv
module cw_rise (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
endmodule

// File: rtl/cw_shifter.sv
module cw_shifter #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_i,
  input  logic         bit_i,
  input  logic         clear_i,
  output logic [W-1:0] word_o,
  output logic         full_o
);
  localparam int unsigned CW = $clog2(W + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(W);

  logic [W-1:0]  sreg_q, sreg_d;
  logic [CW-1:0] cnt_q, cnt_d;

  // Same-cycle shift is visible to the commit logic (word and count look ahead)
  always_comb begin
    sreg_d = sreg_q;
    cnt_d  = cnt_q;
    if (shift_i) begin
      sreg_d = {sreg_q[W-2:0], bit_i};
      if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sreg_q <= '0;
      cnt_q  <= '0;
    end else begin
      sreg_q <= sreg_d;
      cnt_q  <= clear_i ? '0 : cnt_d;
    end
  end

  assign word_o = sreg_d;
  assign full_o = (cnt_d == CNT_MAX);
endmodule

// File: rtl/cw_commit.sv
module cw_commit #(
  parameter int unsigned ADDR_W = 7,
  parameter int unsigned DATA_W = 9,
  localparam int unsigned W     = ADDR_W + DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  logic              full_i,
  input  logic [W-1:0]      word_i,
  output logic              wr_en_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o,
  output logic              err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_en_o <= 1'b0;
      err_o   <= 1'b0;
      addr_o  <= '0;
      data_o  <= '0;
    end else begin
      wr_en_o <= fire_i & full_i;
      err_o   <= fire_i & ~full_i;
      if (fire_i && full_i) begin
        addr_o <= word_i[W-1:DATA_W];
        data_o <= word_i[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ctrl_word_rx.sv
module ctrl_word_rx
  import ctrl_word_pkg::*;
#(
  parameter int unsigned ADDR_BITS = ADDR_W,
  parameter int unsigned DATA_BITS = DATA_W,
  parameter int unsigned SYNC_N    = SYNC_STAGES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ser_clk_i,
  input  logic                 ser_dat_i,
  input  logic                 ser_latch_i,
  output logic                 wr_en_o,
  output logic [ADDR_BITS-1:0] wr_addr_o,
  output logic [DATA_BITS-1:0] wr_data_o,
  output logic                 err_o
);
  localparam int unsigned W = ADDR_BITS + DATA_BITS;

  logic [2:0]   lines_s;
  logic         sclk_rise, latch_rise;
  logic [W-1:0] word;
  logic         full;

  cw_sync #(.N(3), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i({ser_latch_i, ser_dat_i, ser_clk_i}),
    .sync_o (lines_s)
  );

  cw_rise u_sclk_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lines_s[0]),
    .rise_o(sclk_rise)
  );

  cw_rise u_latch_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (lines_s[2]),
    .rise_o(latch_rise)
  );

  cw_shifter #(.W(W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .shift_i(sclk_rise),
    .bit_i  (lines_s[1]),
    .clear_i(latch_rise),
    .word_o (word),
    .full_o (full)
  );

  cw_commit #(.ADDR_W(ADDR_BITS), .DATA_W(DATA_BITS)) u_commit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (latch_rise),
    .full_i (full),
    .word_i (word),
    .wr_en_o(wr_en_o),
    .addr_o (wr_addr_o),
    .data_o (wr_data_o),
    .err_o  (err_o)
  );
endmodule

// File: rtl/ctrl_word_rx_chk.sv
module ctrl_word_rx_chk #(
  parameter int unsigned ADDR_BITS = 7,
  parameter int unsigned DATA_BITS = 9
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ser_latch_i,
  input logic                 wr_en_o,
  input logic [ADDR_BITS-1:0] wr_addr_o,
  input logic [DATA_BITS-1:0] wr_data_o,
  input logic                 err_o
);
  p_strobe_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |=> !wr_en_o);

  p_strobe_from_edge_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o || err_o) |-> ($past(ser_latch_i, 3) && !$past(ser_latch_i, 4)));

  p_err_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);

  p_hold_fields_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> ($stable(wr_addr_o) && $stable(wr_data_o)));

  p_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && err_o));
endmodule

bind ctrl_word_rx ctrl_word_rx_chk #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ser_latch_i(ser_latch_i),
  .wr_en_o    (wr_en_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .err_o      (err_o)
);

// File: tb/ctrl_word_rx_tb_top.sv
module ctrl_word_rx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, sdat = 1'b0, slatch = 1'b0;
  logic       wr_en, err;
  logic [6:0] waddr;
  logic [8:0] wdata;

  int n_run = 0, n_fail = 0;
  int n_wr, n_err, n_both;
  logic [6:0] cap_addr;
  logic [8:0] cap_data;

  always #2.5 clk = ~clk;

  ctrl_word_rx dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ser_clk_i(sclk), .ser_dat_i(sdat), .ser_latch_i(slatch),
    .wr_en_o(wr_en), .wr_addr_o(waddr), .wr_data_o(wdata), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shift_bit(input logic b);
    @(negedge clk); sdat = b;
    wait_clk(3); sclk = 1'b1;
    wait_clk(3); sclk = 1'b0;
    wait_clk(2);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) shift_bit(v[i]);
  endtask

  task automatic watch(input int n);
    n_wr = 0; n_err = 0; n_both = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (wr_en) begin n_wr++; cap_addr = waddr; cap_data = wdata; end
      if (err) n_err++;
      if (wr_en && err) n_both++;
    end
  endtask

  task automatic latch_pulse();
    @(negedge clk); slatch = 1'b1;
    watch(10);
    slatch = 1'b0;
    wait_clk(4);
  endtask

  task automatic t_reset();
    chk(wr_en == 1'b0 && err == 1'b0, "R1 flags", {wr_en, err}, 0);
    chk(waddr == 7'd0 && wdata == 9'd0, "R1 fields", {waddr, wdata}, 0);
  endtask

  task automatic t_basic(input logic [15:0] w);
    send_bits(32'(w), 16);
    latch_pulse();
    chk(n_wr == 1 && n_err == 0, "R3 one strobe", n_wr, 1);
    chk(cap_addr == w[15:9], "R2 addr", cap_addr, w[15:9]);
    chk(cap_data == w[8:0], "R2 data", cap_data, w[8:0]);
    chk(n_both == 0, "R10 exclusive", n_both, 0);
  endtask

  task automatic t_level(input logic [15:0] a, input logic [15:0] b);
    send_bits(32'(a), 16);
    @(negedge clk); slatch = 1'b1;
    watch(10);
    chk(n_wr == 1 && cap_data == a[8:0], "R4 first commit", cap_data, a[8:0]);
    send_bits(32'(b), 16);
    watch(6);
    chk(n_wr == 0 && n_err == 0, "R4 level no effect", n_wr + n_err, 0);
    chk(waddr == a[15:9] && wdata == a[8:0], "R4 outputs held", {waddr, wdata}, a);
    slatch = 1'b0;
    wait_clk(4);
    latch_pulse();
    chk(n_wr == 1 && cap_addr == b[15:9] && cap_data == b[8:0], "R4 next edge commit",
        {cap_addr, cap_data}, b);
  endtask

  task automatic t_short(input logic [15:0] w);
    logic [15:0] prev;
    prev = {waddr, wdata};
    send_bits(32'(w), 15);
    latch_pulse();
    chk(n_err == 1 && n_wr == 0, "R5 error not write", {n_err[7:0], n_wr[7:0]}, 16'h0100);
    chk({waddr, wdata} == prev, "R5 fields held", {waddr, wdata}, prev);
  endtask

  task automatic t_long(input logic [19:0] v);
    send_bits(32'(v), 20);
    latch_pulse();
    chk(n_wr == 1 && {cap_addr, cap_data} == v[15:0], "R6 last sixteen",
        {cap_addr, cap_data}, v[15:0]);
  endtask

  task automatic t_clear(input logic [15:0] a, input logic [15:0] b);
    send_bits(32'(a), 16);
    latch_pulse();
    chk(n_wr == 1, "R7 first word", n_wr, 1);
    send_bits(32'(b), 15);
    latch_pulse();
    chk(n_err == 1 && n_wr == 0, "R7 count cleared", n_err, 1);
  endtask

  task automatic t_same(input logic [15:0] w);
    send_bits(32'(w >> 1), 15);
    @(negedge clk); sdat = w[0]; sclk = 1'b1; slatch = 1'b1;
    watch(10);
    chk(n_wr == 1 && n_err == 0, "R8 same-cycle commit", n_wr, 1);
    chk({cap_addr, cap_data} == w, "R8 word", {cap_addr, cap_data}, w);
    sclk = 1'b0; slatch = 1'b0;
    wait_clk(4);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    wait_clk(3);
    t_reset();
    rst_n = 1'b1;
    wait_clk(3);
    t_reset();
    t_basic(16'hA5C3);
    t_basic(16'h01FF);
    t_level(16'h3E01, 16'hC27E);
    t_short(16'h7FFF);
    t_long(20'hF1234);
    t_clear(16'h5A5A, 16'h2222);
    t_same(16'h8E6D);
    t_same(16'h1310);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule